// File: doc/BRIEF.md
# Keyboard and Game Controller Expansion Port

This block sits as a slave on an 8-bit parallel expansion bus with a 4-bit address, an active-low select strobe and an active-low write enable. It answers three port addresses and leaves the rest of the map to other peripherals. Port `$B` scans a key matrix: a write stores a column number, and a read returns the row bits of that column. Ports `$C` and `$D` serve two game controllers. A write to `$C` captures both controllers' button states. A write to `$D` advances the serial controllers by one bit. Reads of `$C` and `$D` return the status byte of controller 0 and controller 1.

The select strobe comes from outside the block's clock domain. It passes through a synchronizer, and each bus cycle is framed by its synchronized falling edge and rising edge. Read data is taken as a snapshot at the falling edge and held until the strobe is released. A write is applied at the rising edge, using the data seen while the strobe was low. The key matrix and the controller button vectors are plain inputs. Each controller is configured as serial or parallel through a per-pad input.

Top module: `kbpad_port`

## Requirements
- R1: After reset, the stored column is 0 and both controller registers read `8'hFF` (no button pressed, buttons active-low). The data enable is low.
- R2: A write to address `4'hB` stores the data byte as the column number. A later read of `4'hB` returns, in bit r, key-matrix input bit `column*NROWS + r`. Bits at or above NROWS read 0.
- R3: A stored column number at or above NCOLS makes a read of `4'hB` return `8'h00`.
- R4: A write to address `4'hC` loads each controller register from that pad's button input, whatever the write data.
- R5: A read of `4'hC` returns controller 0's register. A read of `4'hD` returns controller 1's register.
- R6: A write to `4'hD` shifts each serial pad's register one place toward bit 0, with 1 entering bit 7. A parallel pad's register is left unchanged.
- R7: `bus_d_oe` is high only while `bus_sel_n` is low during a read of `4'hB`, `4'hC` or `4'hD`. It falls in the same instant that `bus_sel_n` rises, and it stays low for write cycles and for all other addresses.
- R8: A write to an address outside `4'hB` to `4'hD` changes no state of the block.
- R9: While a read strobe stays low, `bus_d_out` keeps the value sampled when the read started, even if the key or button inputs change.
- R10: `bus_d_oe` and read data appear SYNC_STAGES+1 clock edges after `bus_sel_n` falls. A write takes effect SYNC_STAGES+1 edges after `bus_sel_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Bus port address |
| bus_we_n | input | 1 | Active-low write enable, set before the strobe |
| bus_sel_n | input | 1 | Active-low select strobe, asynchronous |
| bus_d_in | input | 8 | Data from the host on writes |
| bus_d_out | output | 8 | Read data toward the host |
| bus_d_oe | output | 1 | Drive enable for the data bus pads |
| key_matrix | input | NCOLS*NROWS | Key state, bit c*NROWS+r is 1 when the key is pressed |
| pad_btn_n | input | 16 | Buttons of pad p in bits p*8+7..p*8, active-low |
| pad_serial | input | 2 | Bit p set makes pad p a serial (shifting) controller |

## Verification
A read answers SYNC_STAGES+1 clock edges after the strobe falls, which is three edges with the default depth. A write's effect on the column or controller registers lands the same number of edges after the strobe rises. The bus task holds each strobe level for five clock periods. It samples the data and enable at the end of the low phase, and it issues the next cycle only after the high phase, so every check falls after its result is due. One directed test samples the enable at edge two and at edge three after the falling strobe, to pin down the latency exactly. Another checks the enable one time step after the strobe rises, because its release does not wait for a clock edge.

// File: rtl/kbpad_pkg.sv
package kbpad_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int PAD_COUNT = 2;

  localparam logic [ADDR_W-1:0] PORT_KBD  = 4'hB;
  localparam logic [ADDR_W-1:0] PORT_PAD0 = 4'hC;
  localparam logic [ADDR_W-1:0] PORT_PAD1 = 4'hD;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_KBD  = 2'd1,
    SEL_PAD0 = 2'd2,
    SEL_PAD1 = 2'd3
  } port_sel_e;

  function automatic port_sel_e decode_port(input logic [ADDR_W-1:0] a);
    case (a)
      PORT_KBD:  return SEL_KBD;
      PORT_PAD0: return SEL_PAD0;
      PORT_PAD1: return SEL_PAD1;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan
  import kbpad_pkg::*;
#(
  parameter int NCOLS = 8,
  parameter int NROWS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NCOLS*NROWS-1:0] matrix,
  output logic [DATA_W-1:0]      rows
);
  localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1;

  logic [DATA_W-1:0] col_q;
  logic [NROWS-1:0]  col_bits;

  always_ff @(posedge clk) begin
    if (rst)        col_q <= '0;
    else if (wr_en) col_q <= wr_data;
  end

  always_comb begin
    col_bits = '0;
    for (int c = 0; c < NCOLS; c++) begin
      if (col_q[COL_W-1:0] == COL_W'(c))
        col_bits = matrix[c*NROWS +: NROWS];
    end
  end

  always_comb begin
    rows = '0;
    if (col_q < DATA_W'(NCOLS))
      rows[NROWS-1:0] = col_bits;
  end

  // R2: the column register only moves on a write strobe
  assert_col_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(col_q));
endmodule

// File: rtl/pad_port.sv
module pad_port
  import kbpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              shift,
  input  logic              serial,
  input  logic [DATA_W-1:0] btn_n,
  output logic [DATA_W-1:0] state
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)                  sh_q <= '1;
    else if (latch)           sh_q <= btn_n;
    else if (shift && serial) sh_q <= {1'b1, sh_q[DATA_W-1:1]};
  end

  assign state = sh_q;

  // R6: a serial shift fills the top bit with "released"
  assert_fill_one_R6: assert property (@(posedge clk) disable iff (rst)
    (shift && serial && !latch) |=> sh_q[DATA_W-1]);

  // R6: a parallel pad ignores shift strobes
  assert_parallel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (shift && !serial && !latch) |=> $stable(sh_q));

  // R4: a latch strobe loads the button inputs
  assert_latch_load_R4: assert property (@(posedge clk) disable iff (rst)
    latch |=> sh_q == $past(btn_n));
endmodule

// File: rtl/kbpad_port.sv
module kbpad_port
  import kbpad_pkg::*;
#(
  parameter int NCOLS       = 8,
  parameter int NROWS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we_n,
  input  logic                        bus_sel_n,
  input  logic [DATA_W-1:0]           bus_d_in,
  output logic [DATA_W-1:0]           bus_d_out,
  output logic                        bus_d_oe,
  input  logic [NCOLS*NROWS-1:0]      key_matrix,
  input  logic [PAD_COUNT*DATA_W-1:0] pad_btn_n,
  input  logic [PAD_COUNT-1:0]        pad_serial
);
  logic sel_s, sel_p;
  logic fall, rise;

  port_sel_e          port_q;
  logic               we_q;
  logic               rd_q;
  logic [DATA_W-1:0]  wdat_q;
  logic [DATA_W-1:0]  dout_q;
  logic [DATA_W-1:0]  kbd_rows;
  logic [DATA_W-1:0]  pad_state [PAD_COUNT];
  logic [DATA_W-1:0]  rd_mux;
  port_sel_e          port_now;

  logic wr_commit;
  logic kbd_wr, pad_latch, pad_shift;

  bus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk (clk),
    .rst (rst),
    .din (bus_sel_n),
    .dout(sel_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_p <= 1'b1;
    else     sel_p <= sel_s;
  end

  assign fall = sel_p & ~sel_s;
  assign rise = ~sel_p & sel_s;

  assign port_now = decode_port(bus_addr);

  always_comb begin
    case (port_now)
      SEL_KBD:  rd_mux = kbd_rows;
      SEL_PAD0: rd_mux = pad_state[0];
      SEL_PAD1: rd_mux = pad_state[1];
      default:  rd_mux = '0;
    endcase
  end

  // cycle framing: address and direction at the falling strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= SEL_NONE;
      we_q   <= 1'b0;
      rd_q   <= 1'b0;
      dout_q <= '0;
    end else if (fall) begin
      port_q <= port_now;
      we_q   <= ~bus_we_n;
      rd_q   <= bus_we_n && (port_now != SEL_NONE);
      dout_q <= rd_mux;
    end else if (rise) begin
      rd_q   <= 1'b0;
    end
  end

  // write data follows the bus while the strobe is low
  always_ff @(posedge clk) begin
    if (rst)         wdat_q <= '0;
    else if (!sel_s) wdat_q <= bus_d_in;
  end

  assign wr_commit = rise & we_q;
  assign kbd_wr    = wr_commit && (port_q == SEL_KBD);
  assign pad_latch = wr_commit && (port_q == SEL_PAD0);
  assign pad_shift = wr_commit && (port_q == SEL_PAD1);

  kbd_scan #(.NCOLS(NCOLS), .NROWS(NROWS)) u_kbd (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (kbd_wr),
    .wr_data(wdat_q),
    .matrix (key_matrix),
    .rows   (kbd_rows)
  );

  generate
    for (genvar p = 0; p < PAD_COUNT; p++) begin : g_pad
      pad_port u_pad (
        .clk   (clk),
        .rst   (rst),
        .latch (pad_latch),
        .shift (pad_shift),
        .serial(pad_serial[p]),
        .btn_n (pad_btn_n[p*DATA_W +: DATA_W]),
        .state (pad_state[p])
      );
    end
  endgenerate

  assign bus_d_out = dout_q;
  assign bus_d_oe  = rd_q & ~bus_sel_n;

  // R9: the read snapshot does not move during an active read
  assert_read_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_q && $past(rd_q)) |-> $stable(dout_q));

  // R7: a drive window never belongs to a write or to a foreign port
  assert_drive_owned_R7: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> (!we_q && port_q != SEL_NONE));

  // R10: a write is committed only on a rising strobe
  assert_commit_rise_R10: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> ($past(sel_s) == 1'b0 && sel_s));
endmodule

// File: tb/tb_kbpad_port.sv
module tb_kbpad_port;
  localparam int CLK_PERIOD = 10;
  localparam int NCOLS = 8;
  localparam int NROWS = 8;
  localparam int SYNC  = 2;
  localparam int HOLD  = 5;
  localparam int NVEC  = 20;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic        bus_we_n;
  logic        bus_sel_n;
  logic [7:0]  bus_d_in;
  logic [7:0]  bus_d_out;
  logic        bus_d_oe;
  logic [NCOLS*NROWS-1:0] key_matrix;
  logic [15:0] pad_btn_n;
  logic [1:0]  pad_serial;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbpad_port #(.NCOLS(NCOLS), .NROWS(NROWS), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we_n(bus_we_n),
    .bus_sel_n(bus_sel_n), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .key_matrix(key_matrix), .pad_btn_n(pad_btn_n),
    .pad_serial(pad_serial)
  );

  // row pattern of column c used for the key matrix stimulus
  function automatic logic [7:0] col_rows(input int c);
    return (8'h11 * 8'(c)) ^ 8'hA5;
  endfunction

  function automatic logic [NCOLS*NROWS-1:0] make_matrix();
    logic [NCOLS*NROWS-1:0] m;
    for (int c = 0; c < NCOLS; c++) m[c*NROWS +: NROWS] = col_rows(c);
    return m;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [3:0] a, input logic wr, input logic [7:0] wd,
                           output logic oe, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we_n = ~wr; bus_d_in = wd;
    @(negedge clk);
    bus_sel_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    oe = bus_d_oe; d = bus_d_out;
    bus_sel_n = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  // {addr, write, wdata, expected oe, expected data, requirement}
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {4'hB, 1'b0, 8'h00, 1'b1, 8'hA5, 4'd1},  // R1 column 0 after reset
    {4'hC, 1'b0, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1 pad 0 idle
    {4'hD, 1'b0, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1 pad 1 idle
    {4'hB, 1'b1, 8'h03, 1'b0, 8'h00, 4'd7},  // R7 no drive on write
    {4'hB, 1'b0, 8'h00, 1'b1, 8'h96, 4'd2},  // R2 column 3
    {4'hB, 1'b1, 8'hF9, 1'b0, 8'h00, 4'd3},  // R3 out of range column
    {4'hB, 1'b0, 8'h00, 1'b1, 8'h00, 4'd3},  // R3 reads zero
    {4'hB, 1'b1, 8'h01, 1'b0, 8'h00, 4'd2},  // R2 column 1
    {4'hB, 1'b0, 8'h00, 1'b1, 8'hB4, 4'd2},  // R2
    {4'hC, 1'b1, 8'h77, 1'b0, 8'h00, 4'd4},  // R4 latch
    {4'hC, 1'b0, 8'h00, 1'b1, 8'h5A, 4'd5},  // R5 pad 0
    {4'hD, 1'b0, 8'h00, 1'b1, 8'hC3, 4'd5},  // R5 pad 1
    {4'hD, 1'b1, 8'h00, 1'b0, 8'h00, 4'd6},  // R6 shift
    {4'hC, 1'b0, 8'h00, 1'b1, 8'hAD, 4'd6},  // R6 serial pad shifted
    {4'hD, 1'b0, 8'h00, 1'b1, 8'hC3, 4'd6},  // R6 parallel pad unchanged
    {4'h5, 1'b0, 8'h00, 1'b0, 8'h00, 4'd7},  // R7 foreign address
    {4'h5, 1'b1, 8'h06, 1'b0, 8'h00, 4'd8},  // R8 foreign write
    {4'hB, 1'b0, 8'h00, 1'b1, 8'hB4, 4'd8},  // R8 column kept
    {4'hD, 1'b1, 8'h00, 1'b0, 8'h00, 4'd6},  // R6 second shift
    {4'hC, 1'b0, 8'h00, 1'b1, 8'hD6, 4'd6}   // R6
  };

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic oe;
    logic [7:0] d;
    rst = 1'b1; bus_addr = 4'h0; bus_we_n = 1'b1; bus_sel_n = 1'b1; bus_d_in = 8'h00;
    key_matrix = make_matrix();
    pad_btn_n = {8'hC3, 8'h5A};
    pad_serial = 2'b01;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", {7'd0, bus_d_oe}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      bus_cycle(VEC[i][25:22], VEC[i][21], VEC[i][20:13], oe, d);
      check($sformatf("R%0d vec %0d oe", VEC[i][3:0], i), {7'd0, oe}, {7'd0, VEC[i][12]});
      if (VEC[i][12])
        check($sformatf("R%0d vec %0d data", VEC[i][3:0], i), d, VEC[i][11:4]);
    end

    // R10 latency of the read enable, R7 immediate release
    @(negedge clk);
    bus_addr = 4'hC; bus_we_n = 1'b1;
    @(negedge clk);
    bus_sel_n = 1'b0;
    repeat (SYNC) @(negedge clk);
    check("R10 oe not yet", {7'd0, bus_d_oe}, 8'h00);
    @(negedge clk);
    check("R10 oe due", {7'd0, bus_d_oe}, 8'h01);
    check("R10 data due", bus_d_out, 8'hD6);
    bus_sel_n = 1'b1;
    #1;
    check("R7 release", {7'd0, bus_d_oe}, 8'h00);
    repeat (HOLD) @(negedge clk);

    // R9 snapshot held while inputs change during a read
    @(negedge clk);
    bus_addr = 4'hB; bus_we_n = 1'b1;
    @(negedge clk);
    bus_sel_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    key_matrix = '0;
    repeat (3) @(negedge clk);
    check("R9 held data", bus_d_out, 8'hB4);
    bus_sel_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    bus_cycle(4'hB, 1'b0, 8'h00, oe, d);
    check("R9 new read sees change", d, 8'h00);
    key_matrix = make_matrix();

    // R4 relatch with new buttons
    pad_btn_n = {8'hF0, 8'h0F};
    bus_cycle(4'hC, 1'b1, 8'h00, oe, d);
    bus_cycle(4'hC, 1'b0, 8'h00, oe, d);
    check("R4 pad 0 relatched", d, 8'h0F);
    bus_cycle(4'hD, 1'b0, 8'h00, oe, d);
    check("R4 pad 1 relatched", d, 8'hF0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule